// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous host and an external asynchronous static RAM that holds one bit at each of 2^20 locations. The memory has separate pins for data going in and data coming out, an active-low chip select and an active-low write strobe. The host hands over one read or one write at a time through a valid/ready handshake. The controller then drives the memory pins with the spacing the memory needs. That spacing is counted in system clock cycles, and the cycle counts are worked out from picosecond timing parameters and the clock period, always rounding up.

A write is shaped by the write strobe. The chip select, the address and the write data are driven first. The strobe then falls one clock later, stays low for the pulse width and rises. The chip select and address stay in place for the hold time after that. A read holds the chip select low, with the strobe high, for the longer of the address and chip-select access times. The output pin is sampled on the last edge of that window, and the bit goes back to the host with a one-cycle strobe. Between any two operations the chip select goes high for at least one cycle, so the memory drops into standby.

The sequencer has six states. IDLE accepts a request. WSETUP, WPULSE and WHOLD form a write. RACCESS is the read window. PAD is the standby gap, and it also waits out the minimum cycle time. The transitions are:
- IDLE to WSETUP on an accepted write.
- IDLE to RACCESS on an accepted read.
- WSETUP to WPULSE after one cycle.
- WPULSE to WHOLD when the pulse count ends.
- WHOLD to PAD when the hold count ends.
- RACCESS to PAD when the access count ends, which is also when the sample is taken.
- PAD to IDLE once the cycle-time count has finished.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset, mem_ce_n and mem_we_n are 1, req_ready is 1 and rd_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from that edge until the sequencer is back in IDLE. A request offered while req_ready is 0 has no effect on the memory.
- R3: For a write, mem_ce_n is 0 and mem_addr and mem_wd already carry the request for exactly one cycle before mem_we_n falls.
- R4: mem_we_n stays 0 for N_WP cycles. N_WP is the larger of ceil(T_WP/CLK) and ceil(T_DS/CLK), which is 3 at the defaults.
- R5: After mem_we_n rises, mem_ce_n stays 0 for N_AH = max(1, ceil(T_AH/CLK)) cycles and then goes to 1. N_AH is 1 at the defaults.
- R6: For a read, mem_ce_n is 0 with mem_we_n 1 for N_AA cycles. N_AA is the larger of ceil(T_AA/CLK) and ceil(T_ACE/CLK), which is 4 at the defaults. mem_rd is sampled on the edge that ends that window, and rd_valid is 1 for exactly the next cycle with that bit on rd_data.
- R7: mem_we_n is never 0 while mem_ce_n is 1. mem_ce_n returns to 1 for at least one cycle between operations.
- R8: Back-to-back requests start no closer together than the minimum spacing: 7 cycles after a write and 6 after a read at the defaults, and never fewer than ceil(T_RC/CLK) cycles.
- R9: mem_addr and mem_wd change only on an accepted request, so they stay stable for as long as mem_ce_n is 0.
- R10: A write never produces an rd_valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Location to access |
| req_wdata | input | 1 | Bit to store on a write |
| rd_valid | output | 1 | One-cycle strobe: rd_data holds read result |
| rd_data | output | 1 | Bit read from memory |
| mem_addr | output | 20 | Address pins of the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_wd | output | 1 | Data into the memory |
| mem_rd | input | 1 | Data out of the memory |

## Verification
The assertions assume a few things about the host side. The host holds req_write, req_addr and req_wdata steady in the cycle its request is taken. The host also never depends on a request that was offered while req_ready was low. The stimulus drives every input at the falling clock edge: it waits for req_ready, raises req_valid for a single cycle and then drops it. An offer made during a busy sequence is likewise pulsed for just one cycle, so it is already gone when IDLE returns. The memory model beside the bench returns the inverted bit until the chip select has been low for the full access window. A sample taken too early therefore shows up as a wrong read value.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS,
        ST_PAD
    } ctl_state_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_tmr.sv
module sram_ctl_tmr #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic pin,
    output logic rd_valid,
    output logic rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample) begin
                rd_data <= pin;
            end
        end
    end

    // R6: the read strobe lasts exactly one cycle
    a_r6_rdv_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned CLK_PS   = 5000,
    parameter int unsigned T_RC_PS  = 20000,
    parameter int unsigned T_AA_PS  = 20000,
    parameter int unsigned T_ACE_PS = 20000,
    parameter int unsigned T_WP_PS  = 15000,
    parameter int unsigned T_DS_PS  = 8000,
    parameter int unsigned T_AH_PS  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    output logic              rd_valid,
    output logic              rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_wd,
    input  logic              mem_rd
);
    localparam int unsigned N_AA  = max2(max2(ceil_div(T_AA_PS, CLK_PS),
                                              ceil_div(T_ACE_PS, CLK_PS)), 1);
    localparam int unsigned N_WP  = max2(max2(ceil_div(T_WP_PS, CLK_PS),
                                              ceil_div(T_DS_PS, CLK_PS)), 1);
    localparam int unsigned N_AH  = max2(ceil_div(T_AH_PS, CLK_PS), 1);
    localparam int unsigned N_RC  = max2(ceil_div(T_RC_PS, CLK_PS), 1);
    localparam int unsigned N_MAX = max2(max2(N_AA, N_WP), max2(N_AH, N_RC));
    localparam int unsigned TMR_W = $clog2(N_MAX + 1);

    ctl_state_e state_q, state_d;

    logic             ph_load, ph_done;
    logic [TMR_W-1:0] ph_val;
    logic             cyc_load, cyc_done;
    logic             accept, sample;

    // phase length timer
    sram_ctl_tmr #(.W(TMR_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    // minimum cycle time timer, started on acceptance
    sram_ctl_tmr #(.W(TMR_W)) u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cyc_load),
        .load_val (TMR_W'(N_RC - 1)),
        .done     (cyc_done)
    );

    sram_ctl_rdcap u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sample),
        .pin      (mem_rd),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign sample    = (state_q == ST_RACCESS) && ph_done;
    assign cyc_load  = accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase timer loads
    always_comb begin
        state_d = state_q;
        ph_load = 1'b0;
        ph_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d = ST_RACCESS;
                        ph_load = 1'b1;
                        ph_val  = TMR_W'(N_AA - 1);
                    end
                end
            end
            ST_WSETUP: begin
                state_d = ST_WPULSE;
                ph_load = 1'b1;
                ph_val  = TMR_W'(N_WP - 1);
            end
            ST_WPULSE: begin
                if (ph_done) begin
                    state_d = ST_WHOLD;
                    ph_load = 1'b1;
                    ph_val  = TMR_W'(N_AH - 1);
                end
            end
            ST_WHOLD: begin
                if (ph_done) begin
                    state_d = ST_PAD;
                end
            end
            ST_RACCESS: begin
                if (ph_done) begin
                    state_d = ST_PAD;
                end
            end
            ST_PAD: begin
                if (cyc_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered memory pins, decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ce_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_addr <= '0;
            mem_wd   <= 1'b0;
        end else begin
            mem_ce_n <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RACCESS});
            mem_we_n <= (state_d != ST_WPULSE);
            if (accept) begin
                mem_addr <= req_addr;
                mem_wd   <= req_wdata;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [TMR_W:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
        end else if (!mem_we_n) begin
            we_low_cnt <= we_low_cnt + 1'b1;
        end else begin
            we_low_cnt <= '0;
        end
    end

    a_r7_we_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    a_r3_setup_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_wd)));

    a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_cnt == (TMR_W+1)'(N_WP)));

    a_r5_deselect_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> $past(mem_we_n));

    a_r9_pins_stable_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_wd)));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    a_r10_no_read_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_we_n));
endmodule

// File: tb/tb_sram_ctl.sv
module tb_sram_ctl;
    localparam int CLK_NS   = 5;
    localparam int EXP_WP   = (15 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_AH   = (1 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_AA   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int EXP_RC   = (20 + CLK_NS - 1) / CLK_NS;
    localparam int PER_WR   = 1 + EXP_WP + EXP_AH + 2;
    localparam int PER_RD   = EXP_AA + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        rd_valid, rd_data;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_wd, mem_rd;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sram_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_wd(mem_wd), .mem_rd(mem_rd)
    );

    // ---------- memory model: stores on strobe rise, data valid after access window
    logic sim_mem [0:1023];
    int   ce_age = 0;

    initial begin
        for (int i = 0; i < 1024; i++) sim_mem[i] = 1'b0;
    end

    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) sim_mem[mem_addr[9:0]] = mem_wd;
    end

    always @(posedge clk) begin
        ce_age <= (mem_ce_n === 1'b0) ? ce_age + 1 : 0;
    end

    assign mem_rd = (ce_age >= EXP_AA - 1) ? sim_mem[mem_addr[9:0]] : ~sim_mem[mem_addr[9:0]];

    // ---------- scoreboard
    bit          exp_mem [int];
    logic        rd_q [$];
    logic [19:0] exp_addr = '0;
    logic        exp_wd = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input logic [19:0] a, input logic d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        exp_addr  = a;
        if (wr) begin
            exp_wd = d;
            exp_mem[int'(a)] = d;
        end else begin
            rd_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 1'b0);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // ---------- monitor
    logic prev_ce = 1'b1, prev_we = 1'b1;
    int   ce_run = 0, we_run = 0, hold_run = 0, period = 0;
    bit   saw_we = 0, have_prev = 0, prev_was_wr = 0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            period++;
            if (!mem_ce_n) begin
                ce_run++;
                if (!mem_we_n) begin
                    we_run++;
                    saw_we = 1;
                end else if (saw_we) begin
                    hold_run++;
                end
            end
            if (!mem_we_n && mem_ce_n)
                check(0, "R7 strobe low while deselected", 1, 0);
            if (prev_we && !mem_we_n) begin
                check(!prev_ce && ce_run == 2, "R3 select one cycle before strobe", ce_run, 2);
                check(mem_addr == exp_addr, "R9 address on write", int'(mem_addr), int'(exp_addr));
                check(mem_wd == exp_wd, "R9 write data", mem_wd, exp_wd);
            end
            if (prev_ce && !mem_ce_n) begin
                check(!req_ready, "R2 ready low when busy", req_ready, 0);
                if (have_prev)
                    check(period >= (prev_was_wr ? PER_WR : PER_RD) && period >= EXP_RC,
                          "R8 request spacing", period, prev_was_wr ? PER_WR : PER_RD);
                period = 0;
                have_prev = 1;
            end
            if (!prev_ce && mem_ce_n) begin
                if (saw_we) begin
                    check(we_run == EXP_WP, "R4 strobe width", we_run, EXP_WP);
                    check(hold_run == EXP_AH, "R5 hold after strobe", hold_run, EXP_AH);
                    check(!rd_valid, "R10 no read strobe on write", rd_valid, 0);
                end else begin
                    check(ce_run == EXP_AA, "R6 read window", ce_run, EXP_AA);
                    check(rd_valid, "R6 read strobe after window", rd_valid, 1);
                    check(mem_addr == exp_addr, "R9 address on read", int'(mem_addr), int'(exp_addr));
                end
                prev_was_wr = saw_we;
                ce_run = 0; we_run = 0; hold_run = 0; saw_we = 0;
            end
            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    check(0, "R6 unexpected read strobe", 1, 0);
                end else begin
                    logic e;
                    e = rd_q.pop_front();
                    check(rd_data == e, "R6 read data", rd_data, e);
                end
            end
            prev_ce = mem_ce_n;
            prev_we = mem_we_n;
        end
    end

    // ---------- watchdog
    initial begin
        #(CLK_NS * 20000);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------- stimulus
    initial begin
        repeat (4) @(negedge clk);
        check(mem_ce_n && mem_we_n && req_ready && !rd_valid, "R1 reset state",
              {mem_ce_n, mem_we_n, req_ready, rd_valid}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && req_ready && !rd_valid, "R1 after reset",
              {mem_ce_n, mem_we_n, req_ready, rd_valid}, 4'b1110);

        do_op(1, 20'h00000, 1'b1);
        do_op(1, 20'hFFFFF, 1'b1);
        do_op(0, 20'h00000, 1'b0);
        do_op(0, 20'hFFFFF, 1'b0);
        do_op(1, 20'h12345, 1'b0);
        do_op(0, 20'h12345, 1'b0);
        do_op(1, 20'hABCDE, 1'b1);
        do_op(0, 20'hABCDE, 1'b0);
        do_op(1, 20'h00000, 1'b0);
        do_op(0, 20'h00000, 1'b0);

        // R2: a request offered while busy must be ignored
        do_op(1, 20'h55555, 1'b1);
        check(!req_ready, "R2 busy after accept", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h2AAAA; req_wdata = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        do_op(0, 20'h2AAAA, 1'b0);
        do_op(0, 20'h55555, 1'b0);

        // idle gaps between operations
        repeat (5) @(negedge clk);
        do_op(0, 20'hABCDE, 1'b0);
        repeat (3) @(negedge clk);
        do_op(1, 20'hABCDE, 1'b0);
        do_op(0, 20'hABCDE, 1'b0);

        repeat (20) @(negedge clk);
        check(rd_q.size() == 0, "R6 all reads returned", rd_q.size(), 0);
        check(mem_ce_n && req_ready, "R7 standby when idle", {mem_ce_n, req_ready}, 2'b11);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule